// File: doc/BRIEF.md
# Single-Cycle 32-Bit Integer Core

This block is a 32-bit processor that completes one instruction in every clock cycle. Each cycle the core drives its program counter onto `pc_o`. The instruction word comes back combinationally on `instr_i`. The core decodes that word, reads two operands from a 32-entry register file and computes a result in the ALU. In the same cycle it either updates the register file or writes the internal data memory, and it selects the next program counter. The supported operations are register-register add, subtract, AND, OR and signed set-less-than. It also supports immediate add, word load, word store, branch-if-equal, branch-if-not-equal and an absolute jump.

The instruction decoder classifies the opcode into one of eight named classes:

- `CL_RTYPE`, `CL_LOAD`, `CL_STORE`, `CL_ADDI`, `CL_BEQ`, `CL_BNE` and `CL_JUMP` for the supported operations.
- `CL_NOP` for any other opcode.

A second process maps each class onto a set of datapath controls. For register-register operations it also decodes the function field. The ALU control works in two levels:

- A 2-bit class code forces an add (address arithmetic) or a subtract (comparison).
- Otherwise the class code defers to the function field.

The data memory is a 32-word array inside the core. It is active only when the upper address bits match the parameter `DM_BASE`.

The write port of the register file and the write port of the data memory both appear on the top-level ports. A testbench can therefore follow every architectural state change while a program runs.

Top module: `sc_core`

## Requirements
- R1: A synchronous reset sets the program counter to 0 and clears every register and every data-memory word to 0.
- R2: Opcode 0 selects a register-register operation that writes register rd (bits [15:11]) from rs (bits [25:21]) and rt (bits [20:16]). The function field (bits [5:0]) selects the operation: 32 is add, 34 is rs minus rt, 36 is AND, 37 is OR, and 42 is 1 when rs is less than rt as signed numbers and 0 otherwise.
- R3: Opcode 8 writes rt with rs plus the sign-extended 16-bit immediate (bits [15:0]). Opcode 35 writes rt with the data-memory word at address rs plus the sign-extended immediate.
- R4: Opcode 43 stores rt at address rs plus the sign-extended immediate. The data memory holds 32 words indexed by address bits [6:2], and it is selected only when address bits [31:7] equal `DM_BASE`. A store to an unselected address changes no word and is not shown on `dm_we_o`. A load from an unselected address returns 0.
- R5: Register 0 always reads as 0. A write addressed to register 0 is discarded and `rf_we_o` stays low.
- R6: Opcode 4 branches when rs equals rt, and opcode 5 branches when they differ. The branch target is PC+4 plus the sign-extended immediate shifted left by 2. When the branch is not taken, the next PC is PC+4.
- R7: Opcode 2 jumps to the upper four bits of PC+4, followed by bits [25:0] of the instruction and then two zero bits.
- R8: Any other opcode, and opcode 0 with a function value not listed in R2, writes neither a register nor memory and advances the PC by 4.
- R9: An instruction whose destination is also one of its sources reads the value held before its own write. The write takes effect on the rising clock edge that ends the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pc_o | output | 32 | Current program counter (instruction address) |
| instr_i | input | 32 | Instruction word at `pc_o`, combinational |
| rf_we_o | output | 1 | Register write taking effect at the coming edge |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value being written to the register |
| dm_we_o | output | 1 | Data-memory write taking effect at the coming edge |
| dm_addr_o | output | 32 | Byte address computed for the memory access |
| dm_wdata_o | output | 32 | Store data (register rt) |

## Verification
Two functions of this core fall into one cycle when an instruction both reads and writes the same register, as in an accumulating add such as r5 = r5 + r1. The same happens when a store in a loop writes a word that a later load reads back. The bench provokes the first case with a counting loop of that form, and provokes the second with a store sequence followed by a load from a stored slot. It also adds stores and loads just outside the base window. An instruction-level model in the bench judges the result. Every cycle, it predicts the program counter, the register write and the memory write from the register and memory values held before that cycle's edge.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam logic [5:0] OPC_RTYPE = 6'd0;
    localparam logic [5:0] OPC_JUMP  = 6'd2;
    localparam logic [5:0] OPC_BEQ   = 6'd4;
    localparam logic [5:0] OPC_BNE   = 6'd5;
    localparam logic [5:0] OPC_ADDI  = 6'd8;
    localparam logic [5:0] OPC_LOAD  = 6'd35;
    localparam logic [5:0] OPC_STORE = 6'd43;

    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_AND = 6'd36;
    localparam logic [5:0] FN_OR  = 6'd37;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        ACL_ADD   = 2'b00,
        ACL_SUB   = 2'b01,
        ACL_FUNCT = 2'b10
    } alu_class_e;

    typedef enum logic [2:0] {
        CL_NOP,
        CL_RTYPE,
        CL_LOAD,
        CL_STORE,
        CL_ADDI,
        CL_BEQ,
        CL_BNE,
        CL_JUMP
    } op_class_e;

    typedef struct packed {
        logic    dst_is_rd;
        logic    b_is_imm;
        logic    wb_from_mem;
        logic    reg_write;
        logic    mem_write;
        logic    br_eq;
        logic    br_ne;
        logic    jump;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode_i,
    input  logic [5:0] funct_i,
    output ctrl_t      ctrl_o
);

    op_class_e  cls;
    alu_class_e acls;
    alu_op_e    fn_op;
    logic       fn_ok;

    // instruction class from opcode
    always_comb begin
        unique case (opcode_i)
            OPC_RTYPE: cls = CL_RTYPE;
            OPC_LOAD:  cls = CL_LOAD;
            OPC_STORE: cls = CL_STORE;
            OPC_ADDI:  cls = CL_ADDI;
            OPC_BEQ:   cls = CL_BEQ;
            OPC_BNE:   cls = CL_BNE;
            OPC_JUMP:  cls = CL_JUMP;
            default:   cls = CL_NOP;
        endcase
    end

    // second level: function field decode
    always_comb begin
        fn_ok = 1'b1;
        unique case (funct_i)
            FN_ADD:  fn_op = ALU_ADD;
            FN_SUB:  fn_op = ALU_SUB;
            FN_AND:  fn_op = ALU_AND;
            FN_OR:   fn_op = ALU_OR;
            FN_SLT:  fn_op = ALU_SLT;
            default: begin
                fn_op = ALU_ADD;
                fn_ok = 1'b0;
            end
        endcase
    end

    // controls per class
    always_comb begin
        ctrl_o = '0;
        ctrl_o.alu_op = ALU_ADD;
        acls = ACL_ADD;
        unique case (cls)
            CL_RTYPE: begin
                ctrl_o.dst_is_rd = 1'b1;
                ctrl_o.reg_write = fn_ok;
                acls = ACL_FUNCT;
            end
            CL_LOAD: begin
                ctrl_o.b_is_imm    = 1'b1;
                ctrl_o.wb_from_mem = 1'b1;
                ctrl_o.reg_write   = 1'b1;
            end
            CL_STORE: begin
                ctrl_o.b_is_imm  = 1'b1;
                ctrl_o.mem_write = 1'b1;
            end
            CL_ADDI: begin
                ctrl_o.b_is_imm  = 1'b1;
                ctrl_o.reg_write = 1'b1;
            end
            CL_BEQ: begin
                ctrl_o.br_eq = 1'b1;
                acls = ACL_SUB;
            end
            CL_BNE: begin
                ctrl_o.br_ne = 1'b1;
                acls = ACL_SUB;
            end
            CL_JUMP: begin
                ctrl_o.jump = 1'b1;
            end
            default: begin
                acls = ACL_ADD;
            end
        endcase

        unique case (acls)
            ACL_SUB:   ctrl_o.alu_op = ALU_SUB;
            ACL_FUNCT: ctrl_o.alu_op = fn_op;
            default:   ctrl_o.alu_op = ALU_ADD;
        endcase
    end

    // R8: an unsupported opcode never produces a write
    always_comb begin
        if (cls == CL_NOP) begin
            assert_nop_quiet_R8: assert (!ctrl_o.reg_write && !ctrl_o.mem_write);
        end
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o,
    output logic         zero_o
);

    always_comb begin
        unique case (op_i)
            ALU_AND: y_o = a_i & b_i;
            ALU_OR:  y_o = a_i | b_i;
            ALU_SUB: y_o = a_i - b_i;
            ALU_SLT: y_o = ($signed(a_i) < $signed(b_i)) ? W'(1) : W'(0);
            default: y_o = a_i + b_i;
        endcase
    end

    assign zero_o = (y_o == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1_i,
    input  logic [AW-1:0] ra2_i,
    output logic [W-1:0]  rd1_o,
    output logic [W-1:0]  rd2_o,
    input  logic          we_i,
    input  logic [AW-1:0] wa_i,
    input  logic [W-1:0]  wd_i
);

    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                regs[i] <= '0;
            end
        end else if (we_i && (wa_i != '0)) begin
            regs[wa_i] <= wd_i;
        end
    end

    assign rd1_o = regs[ra1_i];
    assign rd2_o = regs[ra2_i];

    assert_r0_reads_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (ra1_i == '0) |-> (rd1_o == '0));

    assert_write_visible_R9: assert property (@(posedge clk) disable iff (rst)
        (we_i && (wa_i != '0)) |=> ((ra1_i != $past(wa_i)) || (rd1_o == $past(wd_i))));

endmodule

// File: rtl/sc_dmem.sv
module sc_dmem #(
    parameter int W       = 32,
    parameter int WORDS   = 32,
    parameter int DM_BASE = 0,
    localparam int IDXW   = $clog2(WORDS),
    localparam int BASEW  = 30 - IDXW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [29:0]  waddr_i,
    input  logic         we_i,
    input  logic [W-1:0] wd_i,
    output logic         sel_o,
    output logic [W-1:0] rd_o
);

    logic [W-1:0]    mem [WORDS];
    logic [IDXW-1:0] idx;

    assign idx   = waddr_i[IDXW-1:0];
    assign sel_o = (waddr_i[29:IDXW] == BASEW'(DM_BASE));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= '0;
            end
        end else if (we_i && sel_o) begin
            mem[idx] <= wd_i;
        end
    end

    assign rd_o = sel_o ? mem[idx] : '0;

    assert_store_readback_R4: assert property (@(posedge clk) disable iff (rst)
        (we_i && sel_o) |=> ((waddr_i != $past(waddr_i)) || (rd_o == $past(wd_i))));

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int DM_WORDS = 32,
    parameter int DM_BASE  = 0
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] pc_o,
    input  logic [31:0] instr_i,
    output logic        rf_we_o,
    output logic [4:0]  rf_waddr_o,
    output logic [31:0] rf_wdata_o,
    output logic        dm_we_o,
    output logic [31:0] dm_addr_o,
    output logic [31:0] dm_wdata_o
);

    localparam int XLEN = 32;
    localparam int NREG = 32;

    logic [31:0] pc_q, pc_next, pc_plus4, br_tgt, jmp_tgt, sext;
    logic [31:0] rd1, rd2, alu_b, alu_y, mem_rd, wb_data;
    logic [4:0]  rs, rt, rd, wn;
    logic        alu_zero, br_taken, dm_sel;
    ctrl_t       ctrl;

    assign rs   = instr_i[25:21];
    assign rt   = instr_i[20:16];
    assign rd   = instr_i[15:11];
    assign sext = {{16{instr_i[15]}}, instr_i[15:0]};

    sc_decode dec_i (
        .opcode_i (instr_i[31:26]),
        .funct_i  (instr_i[5:0]),
        .ctrl_o   (ctrl)
    );

    sc_regfile #(.W(XLEN), .N(NREG)) rf_i (
        .clk   (clk),
        .rst   (rst),
        .ra1_i (rs),
        .ra2_i (rt),
        .rd1_o (rd1),
        .rd2_o (rd2),
        .we_i  (ctrl.reg_write),
        .wa_i  (wn),
        .wd_i  (wb_data)
    );

    assign alu_b = ctrl.b_is_imm ? sext : rd2;

    sc_alu #(.W(XLEN)) alu_i (
        .op_i   (ctrl.alu_op),
        .a_i    (rd1),
        .b_i    (alu_b),
        .y_o    (alu_y),
        .zero_o (alu_zero)
    );

    sc_dmem #(.W(XLEN), .WORDS(DM_WORDS), .DM_BASE(DM_BASE)) dm_i (
        .clk     (clk),
        .rst     (rst),
        .waddr_i (alu_y[31:2]),
        .we_i    (ctrl.mem_write),
        .wd_i    (rd2),
        .sel_o   (dm_sel),
        .rd_o    (mem_rd)
    );

    assign wn      = ctrl.dst_is_rd ? rd : rt;
    assign wb_data = ctrl.wb_from_mem ? mem_rd : alu_y;

    // next program counter: jump overrides branch
    assign pc_plus4 = pc_q + 32'd4;
    assign br_tgt   = pc_plus4 + {sext[29:0], 2'b00};
    assign jmp_tgt  = {pc_plus4[31:28], instr_i[25:0], 2'b00};
    assign br_taken = (ctrl.br_eq & alu_zero) | (ctrl.br_ne & ~alu_zero);

    always_comb begin
        if (ctrl.jump)     pc_next = jmp_tgt;
        else if (br_taken) pc_next = br_tgt;
        else               pc_next = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign pc_o       = pc_q;
    assign rf_we_o    = ctrl.reg_write && (wn != '0);
    assign rf_waddr_o = wn;
    assign rf_wdata_o = wb_data;
    assign dm_we_o    = ctrl.mem_write && dm_sel;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rd2;

    assert_seq_step_R6: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.jump && !ctrl.br_eq && !ctrl.br_ne) |=> (pc_q == $past(pc_q) + 32'd4));

    assert_jump_target_R7: assert property (@(posedge clk) disable iff (rst)
        ctrl.jump |=> (pc_q == {$past(pc_plus4[31:28]), $past(instr_i[25:0]), 2'b00}));

    assert_beq_taken_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl.br_eq && (rd1 == rd2)) |=> (pc_q == $past(br_tgt)));

    assert_single_writer_R4: assert property (@(posedge clk) disable iff (rst)
        dm_we_o |-> !rf_we_o);

endmodule

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_o, instr_i, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic [4:0]  rf_waddr_o;
    logic        rf_we_o, dm_we_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] prog [32];
    logic [31:0] m_reg [32];
    logic [31:0] m_mem [32];
    logic [31:0] m_pc;

    always #2 clk = ~clk;

    sc_core dut_i (
        .clk(clk), .rst(rst), .pc_o(pc_o), .instr_i(instr_i),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
    );

    assign instr_i = (pc_o < 32'd128) ? prog[pc_o[6:2]] : 32'd0;

    function automatic logic [31:0] enc_r(int s, int t, int d, int fn);
        return {6'd0, 5'(s), 5'(t), 5'(d), 5'd0, 6'(fn)};
    endfunction
    function automatic logic [31:0] enc_i(int op, int s, int t, int imm);
        return {6'(op), 5'(s), 5'(t), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(int tgt);
        return {6'd2, 26'(tgt)};
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at pc %0h: actual %0h expected %0h", tag, what, m_pc, act, exp);
        end
    endtask

    // instruction-level reference: predict, compare, then commit
    task automatic step_and_check();
        logic [31:0] ins, a, b, se, p4, nxt, v, addr;
        logic [5:0]  op, fn;
        logic [4:0]  s, t, d, wa;
        logic        we, dwe;
        string       tag;
        ins = prog[m_pc[6:2]];
        op = ins[31:26]; fn = ins[5:0];
        s = ins[25:21]; t = ins[20:16]; d = ins[15:11];
        a = m_reg[s]; b = m_reg[t];
        se = {{16{ins[15]}}, ins[15:0]};
        p4 = m_pc + 32'd4;
        nxt = p4; we = 1'b0; dwe = 1'b0; wa = 5'd0; v = 32'd0; addr = a + se;
        tag = "R8";
        case (op)
            6'd0: begin
                tag = ((d == s) || (d == t)) ? "R9" : "R2";
                we = 1'b1; wa = d;
                case (fn)
                    6'd32: v = a + b;
                    6'd34: v = a - b;
                    6'd36: v = a & b;
                    6'd37: v = a | b;
                    6'd42: v = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default: begin we = 1'b0; tag = "R8"; end
                endcase
            end
            6'd8: begin tag = "R3"; we = 1'b1; wa = t; v = a + se; end
            6'd35: begin
                tag = (addr[31:7] == 25'd0) ? "R3" : "R4";
                we = 1'b1; wa = t;
                v = (addr[31:7] == 25'd0) ? m_mem[addr[6:2]] : 32'd0;
            end
            6'd43: begin tag = "R4"; dwe = (addr[31:7] == 25'd0); end
            6'd4: begin tag = "R6"; if (a == b) nxt = p4 + {se[29:0], 2'b00}; end
            6'd5: begin tag = "R6"; if (a != b) nxt = p4 + {se[29:0], 2'b00}; end
            6'd2: begin tag = "R7"; nxt = {p4[31:28], ins[25:0], 2'b00}; end
            default: tag = "R8";
        endcase
        if (we && wa == 5'd0) begin
            we = 1'b0;
            tag = "R5";
        end
        check(tag, "pc", pc_o, m_pc);
        check(tag, "rf_we", {31'd0, rf_we_o}, {31'd0, we});
        if (we) begin
            check(tag, "rf_waddr", {27'd0, rf_waddr_o}, {27'd0, wa});
            check(tag, "rf_wdata", rf_wdata_o, v);
        end
        check(tag, "dm_we", {31'd0, dm_we_o}, {31'd0, dwe});
        if (dwe) begin
            check(tag, "dm_addr", dm_addr_o, addr);
            check(tag, "dm_wdata", dm_wdata_o, b);
            m_mem[addr[6:2]] = b;
        end
        if (we) m_reg[wa] = v;
        m_pc = nxt;
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            prog[i] = enc_j(27);
            m_reg[i] = 32'd0;
            m_mem[i] = 32'd0;
        end
        prog[0]  = enc_i(8, 0, 1, 1);
        prog[1]  = enc_i(8, 0, 2, -3);
        prog[2]  = enc_i(8, 0, 4, 5);
        prog[3]  = enc_r(0, 0, 5, 32);
        prog[4]  = enc_r(5, 1, 5, 32);      // accumulate: reads and writes r5
        prog[5]  = enc_i(8, 7, 7, 4);
        prog[6]  = enc_i(43, 7, 5, 0);
        prog[7]  = enc_r(5, 4, 6, 42);
        prog[8]  = enc_i(5, 6, 0, -5);      // bne back to the accumulate
        prog[9]  = enc_r(2, 4, 8, 34);
        prog[10] = enc_r(8, 4, 9, 36);
        prog[11] = enc_r(8, 4, 10, 37);
        prog[12] = enc_r(2, 1, 11, 42);     // signed: -3 < 1
        prog[13] = enc_i(4, 9, 0, 1);       // beq taken, skips next
        prog[14] = enc_i(8, 0, 12, 99);
        prog[15] = enc_i(35, 0, 13, 8);
        prog[16] = enc_i(8, 0, 0, 7);       // write to r0
        prog[17] = enc_r(0, 1, 14, 32);
        prog[18] = enc_i(43, 0, 1, 128);    // unselected store
        prog[19] = enc_i(35, 0, 15, 0);
        prog[20] = enc_j(22);
        prog[21] = enc_i(8, 0, 12, 77);
        prog[22] = enc_i(5, 1, 1, 5);       // bne not taken
        prog[23] = enc_i(4, 1, 1, 1);       // beq taken
        prog[24] = enc_i(8, 0, 12, 55);
        prog[25] = {6'd63, 26'h3ffffff};    // unknown opcode
        prog[26] = enc_r(1, 1, 17, 0);      // unsupported function value
        prog[27] = enc_i(35, 0, 16, 128);   // unselected load
        prog[28] = enc_j(28);
        m_pc = 32'd0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "pc after reset", pc_o, 32'd0);
        rst = 1'b0;
        for (int c = 0; c < 90; c++) begin
            #1;
            step_and_check();
            @(negedge clk);
        end
        // R1: a word never stored still reads 0 and r12 was never written
        check("R1", "mem word 31", m_mem[31], 32'd0);
        check("R6", "skipped writes r12", m_reg[12], 32'd0);
        check("R4", "loop stores in word 5", m_mem[5], 32'd5);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule